// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block runs single register transactions on a two-wire PHY management link for a host. The host presents a request: a 5-bit PHY address, a 5-bit register address, 16 bits of write data and a direction flag. The engine then produces one complete Clause-22 style frame on its serial clock, data-out and data-out-enable pins. On reads it samples the serial data-in pin and returns the 16-bit value. A one-cycle done pulse marks the end of every transaction.

Each frame has 64 bit slots. There are 32 preamble ones, then a 16-bit header, then 16 data bits. Every slot is one low half of the serial clock followed by one high half. The engine changes data-out only while the serial clock is low. A parameterised divider of the system clock sets the half-period. The pad-level tristate buffer lies outside the block, and so do PHY discovery, link decoding and any host bus wrapper.

Top module: `mdio_frame_engine`

## Requirements
- R1: A synchronous active-high reset, even mid-frame, returns the block to idle with `mdc`=0, `mdo_oe`=0, `busy`=0, `done`=0 and `rd_data`=0.
- R2: Every frame starts with 32 slots in which `mdo`=1 and `mdo_oe`=1.
- R3: Slots 32 to 47 carry a 16-bit header, MSB first. Bits 15:14 are 01. Bits 13:12 are 10 for a read and 01 for a write. Bits 11:7 hold the PHY address and bits 6:2 hold the register address.
- R4: On a write, header bits 1:0 are sent as 1 then 0. The 16 write-data bits follow MSB first in slots 48 to 63. `mdo_oe` stays 1 for the whole frame.
- R5: On a read, header bits 1:0 are 0. `mdo_oe` is 1 for slots 0 to 45 and 0 from slot 46 (the first turnaround slot) through slot 63.
- R6: On a read, `mdi` is sampled in the last system-clock cycle of the low half of slots 48 to 63, MSB first. The 16-bit result is on `rd_data` when `done` pulses.
- R7: Every slot is `mdc` low for HALF_CYCLES system clocks, then high for HALF_CYCLES. A frame has exactly 64 rising edges. The default divider is 50, which gives 2.5 MHz from a 250 MHz clock.
- R8: After the high half of slot 63, `mdc` returns to 0 and stays there while idle. In that same cycle `done` is high for one cycle and `busy` falls.
- R9: A request with `req_valid`=1 while `busy`=0 is accepted, and `busy` is 1 from the next cycle until `done`. A request made while `busy`=1 is ignored: it changes neither the frame in progress nor starts a later one.
- R10: Only reads update `rd_data`. A write leaves it at the value of the last read, or 0 after reset.
- R11: `mdo` changes only while `mdc` is low, and holds steady through each high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_write | input | 1 | 1 = write transaction, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management serial clock |
| mdo | output | 1 | Serial data toward the PHY |
| mdo_oe | output | 1 | Enable for the external data driver |
| mdi | input | 1 | Serial data from the PHY |

## Verification
The hardest situation to reach from the ports is a second request that arrives halfway through a frame. It must leave no trace in the serial stream and must not queue a later frame. The bench acts as the PHY. It decodes the stream on every `mdc` rising edge and, during one transaction, raises a conflicting request near slot 20. It then checks both the captured frame and the quiet period after `done`. A reset asserted in the middle of a frame is the other hard case, and a later clean frame confirms that the block recovered. Read data is fed on `mdi` only after each falling edge of `mdc`, so a wrong sampling slot shows up as a shifted value.

// File: rtl/mdio_fe_pkg.sv
package mdio_fe_pkg;
    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 16;
    localparam int DATA_BITS = 16;
    localparam int SLOTS     = PRE_BITS + HDR_BITS + DATA_BITS;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int SR_W      = HDR_BITS + DATA_BITS;

    typedef struct packed {
        logic                 busy;
        logic                 write;
        logic                 high;
        logic [SLOT_W-1:0]    slot;
        logic [SR_W-1:0]      tx;
        logic [DATA_BITS-1:0] rx;
        logic                 done;
    } fe_state_t;
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
    parameter int HALF_CYCLES = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mdio_hdr_pack.sv
module mdio_hdr_pack (
    input  logic        write,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    output logic [15:0] hdr
);
    always_comb begin
        hdr[15:14] = 2'b01;
        hdr[13:12] = write ? 2'b01 : 2'b10;
        hdr[11:7]  = phy;
        hdr[6:2]   = regad;
        hdr[1:0]   = write ? 2'b10 : 2'b00;
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_fe_pkg::*;
#(
    parameter int HALF_CYCLES = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdc,
    output logic        mdo,
    output logic        mdo_oe,
    input  logic        mdi
);
    localparam logic [SLOT_W-1:0] HDR_START  = SLOT_W'(PRE_BITS);
    localparam logic [SLOT_W-1:0] TA_START   = SLOT_W'(PRE_BITS + HDR_BITS - 2);
    localparam logic [SLOT_W-1:0] DATA_START = SLOT_W'(PRE_BITS + HDR_BITS);
    localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(SLOTS - 1);

    fe_state_t     st_d, st_q;
    logic          tick;
    logic [15:0]   hdr;
    logic          accept;

    mdio_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (st_q.busy),
        .tick (tick)
    );

    mdio_hdr_pack u_hdr (
        .write (req_write),
        .phy   (req_phy),
        .regad (req_reg),
        .hdr   (hdr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        accept    = req_valid && !st_q.busy;
        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.write = req_write;
            st_d.high  = 1'b0;
            st_d.slot  = '0;
            st_d.tx    = {hdr, req_write ? req_wdata : 16'h0000};
        end else if (st_q.busy && tick) begin
            if (!st_q.high) begin
                st_d.high = 1'b1;
                if (!st_q.write && st_q.slot >= DATA_START)
                    st_d.rx = {st_q.rx[DATA_BITS-2:0], mdi};
            end else begin
                st_d.high = 1'b0;
                if (st_q.slot >= HDR_START)
                    st_d.tx = {st_q.tx[SR_W-2:0], 1'b0};
                if (st_q.slot == LAST_SLOT) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.slot = st_q.slot + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign rd_data = st_q.rx;
    assign mdc     = st_q.busy && st_q.high;
    assign mdo     = st_q.busy && ((st_q.slot < HDR_START) || st_q.tx[SR_W-1]);
    assign mdo_oe  = st_q.busy && (st_q.write || (st_q.slot < TA_START));
endmodule

// File: rtl/mdio_fe_checker.sv
module mdio_fe_checker #(
    parameter int HALF_CYCLES = 50
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic        busy,
    input logic        done,
    input logic        mdc,
    input logic        mdo,
    input logic        mdo_oe
);
    localparam int HW = $clog2(HALF_CYCLES + 2) + 1;
    localparam logic [HW-1:0] HALF_V = HW'(HALF_CYCLES);

    logic          wr_lat;
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_lat <= 1'b0;
            hi_cnt <= '0;
        end else begin
            if (req_valid && !busy) wr_lat <= req_write;
            if (!mdc)                       hi_cnt <= '0;
            else if (hi_cnt != {HW{1'b1}})  hi_cnt <= hi_cnt + 1'b1;
        end
    end

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdo_oe));
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_busy_end_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    p_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);
    p_start_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));
    p_write_drive_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_lat) |-> mdo_oe);
    p_high_len_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(mdc) |-> (hi_cnt == HALF_V));
    p_mdo_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> $stable(mdo));
endmodule

bind mdio_frame_engine mdio_fe_checker #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .busy      (busy),
    .done      (done),
    .mdc       (mdc),
    .mdo       (mdo),
    .mdo_oe    (mdo_oe)
);

// File: tb/sim_mdio_frame_engine.sv
module sim_mdio_frame_engine;
    localparam int HALF = 3;
    localparam int NV   = 6;
    // {write, phy[4:0], reg[4:0], wdata[15:0], phy_read_data[15:0]}
    localparam logic [42:0] VEC [NV] = '{
        {1'b0, 5'h01, 5'h01, 16'h0000, 16'h8001},
        {1'b1, 5'h1F, 5'h00, 16'hA5C3, 16'h0000},
        {1'b0, 5'h1F, 5'h1F, 16'h0000, 16'hFFFF},
        {1'b1, 5'h00, 5'h1F, 16'h0000, 16'h1234},
        {1'b0, 5'h10, 5'h12, 16'h0000, 16'h3C5A},
        {1'b1, 5'h0A, 5'h15, 16'hFFFF, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, mdi = 1'b0;
    logic [4:0] req_phy = '0, req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic busy, done, mdc, mdo, mdo_oe;
    logic [15:0] rd_data;

    int checks = 0, fails = 0, cycles = 0;
    logic [15:0] last_rd = 16'h0000;

    always #2 clk = ~clk;

    mdio_frame_engine #(.HALF_CYCLES(HALF)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data),
        .mdc(mdc), .mdo(mdo), .mdo_oe(mdo_oe), .mdi(mdi)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic run_frame(input logic w, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input logic [15:0] prd,
                             input logic inject);
        logic [63:0] cap_mdo = '0, cap_oe = '0, exp_oe;
        logic [15:0] hdr_exp, hdr_cap, dat_cap;
        int n = 0, len = 0, bad_len = 0;
        logic prev = 1'b0, seen_done = 1'b0;
        logic [15:0] rd_at_done = '0;
        hdr_exp = {2'b01, w ? 2'b01 : 2'b10, phy, rg, w ? 2'b10 : 2'b00};
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_phy = phy; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
        for (int c = 0; c < 64 * 2 * HALF + 20; c++) begin
            if (req_valid) req_valid = 1'b0;
            if (mdc === prev) len++;
            else begin
                if (len != HALF) bad_len++;
                len = 1;
                if (mdc && n < 64) begin
                    cap_mdo[n] = mdo;
                    cap_oe[n]  = mdo_oe;
                    n++;
                end else if (!mdc) begin
                    if (n >= 48 && n < 64) mdi = prd[15 - (n - 48)];
                    else if (n == 47) mdi = 1'b0;
                    else mdi = 1'b1;
                    if (inject && n == 20) begin
                        req_valid = 1'b1; req_write = ~w; req_phy = ~phy;
                        req_reg = ~rg; req_wdata = ~wd;
                    end
                end
                prev = mdc;
            end
            if (done === 1'b1) begin
                seen_done = 1'b1;
                rd_at_done = rd_data;
                break;
            end
            @(negedge clk);
        end
        check(seen_done, "R8 done pulse seen", 64'(seen_done), 64'd1);
        check(n == 64, "R7 rising edges per frame", 64'(n), 64'd64);
        check(bad_len == 0, "R7 half-period length", 64'(bad_len), 64'd0);
        check(cap_mdo[31:0] == 32'hFFFF_FFFF && cap_oe[31:0] == 32'hFFFF_FFFF,
              "R2 preamble", {cap_oe[31:0], cap_mdo[31:0]}, 64'hFFFF_FFFF_FFFF_FFFF);
        for (int i = 0; i < 16; i++) begin
            hdr_cap[15 - i] = cap_mdo[32 + i];
            dat_cap[15 - i] = cap_mdo[48 + i];
        end
        check(hdr_cap[15:2] == hdr_exp[15:2], "R3 header", 64'(hdr_cap), 64'(hdr_exp));
        exp_oe = w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_3FFF_FFFF_FFFF;
        if (w) begin
            check(hdr_cap[1:0] == 2'b10, "R4 write turnaround", 64'(hdr_cap[1:0]), 64'd2);
            check(dat_cap == wd, "R4 write data", 64'(dat_cap), 64'(wd));
            check(cap_oe == exp_oe, "R4 write enable", cap_oe, exp_oe);
            check(rd_at_done == last_rd, "R10 read data held on write",
                  64'(rd_at_done), 64'(last_rd));
        end else begin
            check(cap_oe == exp_oe, "R5 read enable release", cap_oe, exp_oe);
            check(rd_at_done == prd, "R6 read data", 64'(rd_at_done), 64'(prd));
            last_rd = prd;
        end
        check(busy === 1'b0 && mdc === 1'b0, "R8 idle at done",
              {62'd0, busy, mdc}, 64'd0);
        begin
            int extra = 0;
            for (int c = 0; c < 8 * HALF + 10; c++) begin
                @(negedge clk);
                if (mdc !== 1'b0 || busy !== 1'b0 || done !== 1'b0 || mdo_oe !== 1'b0)
                    extra++;
            end
            check(extra == 0, inject ? "R9 busy request ignored" : "R8 quiet after done",
                  64'(extra), 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(mdc === 1'b0 && mdo_oe === 1'b0 && busy === 1'b0 && done === 1'b0
              && rd_data === 16'h0000, "R1 reset state",
              {44'd0, rd_data, mdc, mdo_oe, busy, done}, 64'd0);
        rst = 1'b0;
        for (int v = 0; v < NV; v++)
            run_frame(VEC[v][42], VEC[v][41:37], VEC[v][36:32], VEC[v][31:16],
                      VEC[v][15:0], 1'b0);
        // busy-time request must be ignored (R9)
        run_frame(1'b0, 5'h05, 5'h0C, 16'h0000, 16'h5A0F, 1'b1);
        run_frame(1'b1, 5'h15, 5'h0A, 16'h0F0F, 16'h0000, 1'b1);
        // reset in the middle of a frame (R1)
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_phy = 5'h03; req_reg = 5'h04;
        req_wdata = 16'hBEEF;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (40 * HALF) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(mdc === 1'b0 && mdo_oe === 1'b0 && busy === 1'b0 && done === 1'b0
              && rd_data === 16'h0000, "R1 reset mid-frame",
              {44'd0, rd_data, mdc, mdo_oe, busy, done}, 64'd0);
        rst = 1'b0;
        last_rd = 16'h0000;
        run_frame(1'b1, 5'h03, 5'h04, 16'h1357, 16'h0000, 1'b0);
        run_frame(1'b0, 5'h03, 5'h04, 16'h0000, 16'hC001, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule